// File: doc/BRIEF.md
# Multiplexed Bus Register Slave

This block is the host-facing register port of a line interface device. A host reaches it over one 8-bit bus that carries the address first and the data afterwards. The block captures the address when the address strobe falls. It then serves one read or write at that address into a small register file. The file holds receive signaling bytes, transmit signaling bytes, channel blocking bytes, control bytes, two interrupt masks and a test byte.

A static convention input selects how the two strobe pins are read. In the first convention they are an active-low read strobe and an active-low write strobe. In the second they are an active-high data strobe and a direction line, high for read. All bus pins, the shared data lines included, pass through a two-flop synchronizer into the internal clock domain, and the block acts on edges of the synchronized copies. The core loads the receive signaling bytes through a separate update port. The host cannot write them.

Top module: `mbus_reg_slave`

## Requirements
- R1: After synchronous reset `ad_oe` is low and every mapped register reads 0x00. This includes the test register at 0x7D.
- R2: With `conv_sel`=0, `strobe_a` is an active-low read strobe and `strobe_b` is an active-low write strobe. With `conv_sel`=1, `strobe_a` is an active-high data strobe and `strobe_b` gives the direction (1 = read, 0 = write).
- R3: The target address is the value on `ad_in` just before `addr_strobe` falls. Changes on `ad_in` after that fall do not change which register a read or write reaches.
- R4: Write data is the `ad_in` value present at the trailing edge of the strobe. In convention 0 that edge is the rise of `strobe_b`. In convention 1 it is the fall of `strobe_a`, and only while the direction line is low.
- R5: `ad_oe` is high and `ad_out` carries the addressed byte within four clock edges of a read strobe becoming active. A read strobe is `strobe_a` low in convention 0, or `strobe_a` high with `strobe_b` high in convention 1.
- R6: `ad_oe` returns low within four clock edges after the read strobe ends. That is `strobe_a` rising in convention 0, or `strobe_a` falling in convention 1. `ad_oe` stays low for the whole of a convention-1 write.
- R7: Addresses 0x6C–0x6F and 0x73–0x7F are host read/write and read back the last value written.
- R8: Addresses 0x63–0x6B are read-only for the host, and host writes to them are ignored. They take the value written through the update port (`upd_we`, `upd_addr`, `upd_data`).
- R9: Reads of any address outside 0x63–0x6F and 0x73–0x7F return 0x00, and host writes there have no effect.
- R10: The test register at 0x7D resets to 0x00. A host write of 0x00 clears it after any other value.
- R11: When an update-port write targets the read-only register being read in the same cycle, `ad_out` shows the new byte in that cycle. An update to a different address leaves `ad_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_sel | input | 1 | Static strobe convention select |
| addr_strobe | input | 1 | Address latch strobe, address taken on its fall |
| strobe_a | input | 1 | Read strobe (conv 0, active low) or data strobe (conv 1, active high) |
| strobe_b | input | 1 | Write strobe (conv 0, active low) or direction (conv 1, 1 = read) |
| ad_in | input | 8 | Shared bus, input side |
| ad_out | output | 8 | Shared bus, output side, 0x00 when not driving |
| ad_oe | output | 1 | Output enable for the shared bus |
| upd_we | input | 1 | Update port write enable |
| upd_addr | input | 8 | Update port address |
| upd_data | input | 8 | Update port data |

## Verification
A host read of a receive signaling register and a core update of that same register can fall in one clock cycle. The bench holds a convention-0 read of 0x65 with the bus driven. Just after a falling clock edge it presents an update to 0x65, and before the next rising edge it checks that `ad_out` already shows the new byte. After that edge it checks that the byte stays. It then updates a neighbouring address and checks that the byte on the bus does not change. Sweeps over all 256 addresses in both conventions judge every read against values the bench computes from the address map.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    localparam int AW       = 8;
    localparam int DW       = 8;
    localparam int NUM_RO   = 9;
    localparam int NUM_RW   = 17;
    localparam int SEL_W    = 5;
    localparam int RO_IDX_W = $clog2(NUM_RO);
    localparam int RW_IDX_W = $clog2(NUM_RW);

    localparam logic [AW-1:0] RO_FIRST = 8'h63;
    localparam logic [AW-1:0] RO_LAST  = 8'h6B;
    localparam logic [AW-1:0] BLK_FIRST = 8'h6C;
    localparam logic [AW-1:0] BLK_LAST  = 8'h6F;
    localparam logic [AW-1:0] TX_FIRST = 8'h73;
    localparam logic [AW-1:0] TX_LAST  = 8'h7F;
    localparam logic [AW-1:0] TEST_ADDR = 8'h7D;

    // read/write slots: 0..3 for the blocking/mask group, 4..16 for the upper group
    localparam int BLK_SLOTS = int'(BLK_LAST - BLK_FIRST) + 1;
    localparam int TEST_IDX  = BLK_SLOTS + int'(TEST_ADDR - TX_FIRST);

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_RO   = 2'd1,
        RK_RW   = 2'd2
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e          kind;
        logic [SEL_W-1:0]   idx;
    } reg_sel_t;

    typedef struct packed {
        logic               wr_commit;
        logic [DW-1:0]      wr_data;
        logic               rd_drive;
    } bus_evt_t;

    function automatic reg_sel_t decode_addr(input logic [AW-1:0] a);
        reg_sel_t s;
        s.kind = RK_NONE;
        s.idx  = '0;
        if (a >= RO_FIRST && a <= RO_LAST) begin
            s.kind = RK_RO;
            s.idx  = SEL_W'(a - RO_FIRST);
        end else if (a >= BLK_FIRST && a <= BLK_LAST) begin
            s.kind = RK_RW;
            s.idx  = SEL_W'(a - BLK_FIRST);
        end else if (a >= TX_FIRST && a <= TX_LAST) begin
            s.kind = RK_RW;
            s.idx  = SEL_W'(a - TX_FIRST) + SEL_W'(BLK_SLOTS);
        end
        return s;
    endfunction

endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES:0][W-1:0] chain;

    assign chain[0] = d;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[g+1] <= '0;
            else     chain[g+1] <= chain[g];
        end
    end

    assign q = chain[STAGES];

endmodule

// File: rtl/mbus_strobe.sv
module mbus_strobe
    import mbus_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          conv_sel,
    input  logic          as_pin,
    input  logic          sa_pin,
    input  logic          sb_pin,
    input  logic [DW-1:0] ad_pin,
    output logic [AW-1:0] addr_q,
    output bus_evt_t      evt
);

    localparam int SW    = DW + 3;
    localparam int WARM  = STAGES + 1;
    localparam int CNT_W = $clog2(WARM + 1) + 1;

    logic [SW-1:0]    raw_v, syn_v, prev_v;
    logic [CNT_W-1:0] warm_cnt;
    logic             warm;
    logic             as_s, sa_s, sb_s, as_p, sa_p, sb_p;
    logic [DW-1:0]    ad_p;
    logic             as_fall;

    assign raw_v = {as_pin, sa_pin, sb_pin, ad_pin};

    mbus_sync #(.W(SW), .STAGES(STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_v),
        .q   (syn_v)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_v   <= '0;
            warm_cnt <= '0;
        end else begin
            prev_v <= syn_v;
            if (!warm) warm_cnt <= warm_cnt + 1'b1;
        end
    end

    assign warm = (warm_cnt >= CNT_W'(WARM));

    assign as_s = syn_v[SW-1];
    assign sa_s = syn_v[SW-2];
    assign sb_s = syn_v[SW-3];
    assign as_p = prev_v[SW-1];
    assign sa_p = prev_v[SW-2];
    assign sb_p = prev_v[SW-3];
    assign ad_p = prev_v[DW-1:0];

    assign as_fall = warm && as_p && !as_s;

    always_comb begin
        evt.wr_data = ad_p;
        if (!conv_sel) begin
            evt.wr_commit = warm && !sb_p && sb_s;
            evt.rd_drive  = warm && !sa_s;
        end else begin
            evt.wr_commit = warm && sa_p && !sa_s && !sb_p;
            evt.rd_drive  = warm && sa_s && sb_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          addr_q <= '0;
        else if (as_fall) addr_q <= ad_p;
    end

    // R3: the latched address only moves on an address strobe fall
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !as_fall |=> $stable(addr_q));

    // R6: a released read strobe in convention 0 never drives the bus
    p_release_c0_r6: assert property (@(posedge clk) disable iff (rst)
        (!conv_sel && sa_s) |-> !evt.rd_drive);

    // R6: a write direction in convention 1 never drives the bus
    p_no_drive_write_r6: assert property (@(posedge clk) disable iff (rst)
        (conv_sel && !sb_s) |-> !evt.rd_drive);

    // R4: no write commits while the read direction was held in convention 1
    p_no_write_on_read_r4: assert property (@(posedge clk) disable iff (rst)
        (conv_sel && sb_p) |-> !evt.wr_commit);

endmodule

// File: rtl/mbus_regfile.sv
module mbus_regfile
    import mbus_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          hw_we,
    input  logic [AW-1:0] hw_addr,
    input  logic [DW-1:0] hw_data,
    input  logic [AW-1:0] rd_addr,
    input  logic          upd_we,
    input  logic [AW-1:0] upd_addr,
    input  logic [DW-1:0] upd_data,
    output logic [DW-1:0] rd_data
);

    logic [NUM_RO-1:0][DW-1:0] ro_q;
    logic [NUM_RW-1:0][DW-1:0] rw_q;
    reg_sel_t hw_sel, up_sel, rd_sel;
    logic     up_hit;

    always_comb begin
        hw_sel = decode_addr(hw_addr);
        up_sel = decode_addr(upd_addr);
        rd_sel = decode_addr(rd_addr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ro_q <= '0;
            rw_q <= '0;
        end else begin
            if (upd_we && up_sel.kind == RK_RO)
                ro_q[up_sel.idx[RO_IDX_W-1:0]] <= upd_data;
            if (hw_we && hw_sel.kind == RK_RW)
                rw_q[hw_sel.idx[RW_IDX_W-1:0]] <= hw_data;
        end
    end

    assign up_hit = upd_we && (up_sel.kind == RK_RO) && (upd_addr == rd_addr);

    always_comb begin
        unique case (rd_sel.kind)
            RK_RO:   rd_data = up_hit ? upd_data : ro_q[rd_sel.idx[RO_IDX_W-1:0]];
            RK_RW:   rd_data = rw_q[rd_sel.idx[RW_IDX_W-1:0]];
            default: rd_data = '0;
        endcase
    end

    // R8: read-only bytes change only through the update port
    p_ro_host_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        !upd_we |=> $stable(ro_q));

    // R10: the test byte is zero on leaving reset
    p_test_reset_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (rw_q[TEST_IDX] == '0));

    // R9: unmapped reads return zero
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_sel.kind == RK_NONE) |-> (rd_data == '0));

    // R11: a same-cycle update to the addressed read-only byte is visible
    p_bypass_r11: assert property (@(posedge clk) disable iff (rst)
        (upd_we && upd_addr == rd_addr && rd_sel.kind == RK_RO) |-> (rd_data == upd_data));

    // R7: a host write to a read/write slot lands there
    p_rw_lands_r7: assert property (@(posedge clk) disable iff (rst)
        (hw_we && hw_sel.kind == RK_RW) |=>
            (rw_q[$past(hw_sel.idx[RW_IDX_W-1:0])] == $past(hw_data)));

endmodule

// File: rtl/mbus_reg_slave.sv
module mbus_reg_slave
    import mbus_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       conv_sel,
    input  logic       addr_strobe,
    input  logic       strobe_a,
    input  logic       strobe_b,
    input  logic [7:0] ad_in,
    output logic [7:0] ad_out,
    output logic       ad_oe,
    input  logic       upd_we,
    input  logic [7:0] upd_addr,
    input  logic [7:0] upd_data
);

    logic [AW-1:0] addr_q;
    bus_evt_t      evt;
    logic [DW-1:0] rd_data;

    mbus_strobe #(.STAGES(SYNC_STAGES)) u_strobe (
        .clk      (clk),
        .rst      (rst),
        .conv_sel (conv_sel),
        .as_pin   (addr_strobe),
        .sa_pin   (strobe_a),
        .sb_pin   (strobe_b),
        .ad_pin   (ad_in),
        .addr_q   (addr_q),
        .evt      (evt)
    );

    mbus_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .hw_we    (evt.wr_commit),
        .hw_addr  (addr_q),
        .hw_data  (evt.wr_data),
        .rd_addr  (addr_q),
        .upd_we   (upd_we),
        .upd_addr (upd_addr),
        .upd_data (upd_data),
        .rd_data  (rd_data)
    );

    assign ad_oe  = evt.rd_drive;
    assign ad_out = evt.rd_drive ? rd_data : '0;

    // R5: whenever the bus is not driven the output lines read zero
    p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
        !ad_oe |-> (ad_out == '0));

    // R1: the bus is released in the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !ad_oe);

endmodule

// File: tb/sim_mbus_reg_slave.sv
module sim_mbus_reg_slave;

    localparam int CLK_T = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       conv_sel = 1'b0;
    logic       addr_strobe = 1'b0;
    logic       strobe_a = 1'b1;
    logic       strobe_b = 1'b1;
    logic [7:0] ad_in = 8'h00;
    logic [7:0] ad_out;
    logic       ad_oe;
    logic       upd_we = 1'b0;
    logic [7:0] upd_addr = 8'h00;
    logic [7:0] upd_data = 8'h00;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_T/2) clk = ~clk;

    mbus_reg_slave u0 (
        .clk         (clk),
        .rst         (rst),
        .conv_sel    (conv_sel),
        .addr_strobe (addr_strobe),
        .strobe_a    (strobe_a),
        .strobe_b    (strobe_b),
        .ad_in       (ad_in),
        .ad_out      (ad_out),
        .ad_oe       (ad_oe),
        .upd_we      (upd_we),
        .upd_addr    (upd_addr),
        .upd_data    (upd_data)
    );

    function automatic int kind_of(input int a);
        if (a >= 8'h63 && a <= 8'h6B) return 1;
        if ((a >= 8'h6C && a <= 8'h6F) || (a >= 8'h73 && a <= 8'h7F)) return 2;
        return 0;
    endfunction

    function automatic logic [7:0] wv0(input int a); return 8'((a * 7 + 8'h11) & 8'hFF); endfunction
    function automatic logic [7:0] uv(input int a);  return 8'(~a) ^ 8'h3C; endfunction
    function automatic logic [7:0] wv1(input int a); return 8'(a) ^ 8'hA7; endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic host_addr(input logic [7:0] a);
        ad_in = a;
        addr_strobe = 1'b1;
        tick(3);
        addr_strobe = 1'b0;
        tick(2);
    endtask

    task automatic host_write(input logic [7:0] a, input logic [7:0] d);
        host_addr(a);
        ad_in = d;
        if (!conv_sel) begin
            strobe_b = 1'b0;
            tick(4);
            strobe_b = 1'b1;
            tick(4);
        end else begin
            strobe_b = 1'b0;
            tick(1);
            strobe_a = 1'b1;
            tick(3);
            check(ad_oe == 1'b0, "R6 no drive during write", ad_oe, 0);
            strobe_a = 1'b0;
            tick(4);
            strobe_b = 1'b1;
            tick(1);
        end
    endtask

    task automatic host_read(input logic [7:0] a, output logic [7:0] v,
                             output logic oe_mid, output logic oe_after);
        host_addr(a);
        ad_in = a ^ 8'h01;
        if (!conv_sel) strobe_a = 1'b0;
        else           strobe_a = 1'b1;
        tick(4);
        #1;
        oe_mid = ad_oe;
        v      = ad_out;
        if (!conv_sel) strobe_a = 1'b1;
        else           strobe_a = 1'b0;
        tick(4);
        #1;
        oe_after = ad_oe;
    endtask

    task automatic upd(input logic [7:0] a, input logic [7:0] d);
        upd_we = 1'b1; upd_addr = a; upd_data = d;
        tick(1);
        upd_we = 1'b0;
    endtask

    task automatic sweep_read(input int lo, input int hi, input int phase);
        logic [7:0] v;
        logic om, oa;
        logic [7:0] e;
        for (int a = lo; a <= hi; a++) begin
            host_read(8'(a), v, om, oa);
            case (kind_of(a))
                1: e = (phase == 0) ? 8'h00 : uv(a);
                2: e = (phase == 2) ? wv1(a) : wv0(a);
                default: e = 8'h00;
            endcase
            check(om == 1'b1, "R5 drive during read", om, 1);
            check(oa == 1'b0, "R6 release after read", oa, 0);
            case (kind_of(a))
                1: check(v == e, "R8 read-only byte", v, e);
                2: check(v == e, "R7 read/write byte (R3 addr, R4 data)", v, e);
                default: check(v == e, "R9 unmapped zero", v, e);
            endcase
        end
    endtask

    task automatic go_conv(input logic c);
        if (c) begin
            conv_sel = 1'b1;
            strobe_b = 1'b1;
            strobe_a = 1'b0;
        end else begin
            strobe_a = 1'b1;
            strobe_b = 1'b1;
            conv_sel = 1'b0;
        end
        tick(5);
    endtask

    initial begin
        logic [7:0] v;
        logic om, oa;
        rst = 1'b1;
        tick(5);
        rst = 1'b0;
        #1;
        check(ad_oe == 1'b0, "R1 oe after reset", ad_oe, 0);
        tick(5);

        // R1 / R10: test byte and a few mapped bytes are zero after reset
        host_read(8'h7D, v, om, oa);
        check(v == 8'h00, "R1 R10 test byte reset", v, 0);
        host_read(8'h63, v, om, oa);
        check(v == 8'h00, "R1 read-only reset", v, 0);
        host_read(8'h6C, v, om, oa);
        check(v == 8'h00, "R1 read/write reset", v, 0);

        // R2 convention 0: write every address, read all back
        for (int a = 0; a < 256; a++) host_write(8'(a), wv0(a));
        sweep_read(0, 255, 0);

        // R8: load read-only bytes through the update port
        for (int a = 8'h63; a <= 8'h6B; a++) upd(8'(a), uv(a));

        // R2 convention 1 reads
        go_conv(1'b1);
        sweep_read(8'h60, 8'h80, 1);

        // R4 convention 1 writes over the whole space
        for (int a = 0; a < 256; a++) host_write(8'(a), wv1(a));
        sweep_read(0, 255, 2);

        // R10: set then clear the test byte
        host_write(8'h7D, 8'hFF);
        host_read(8'h7D, v, om, oa);
        check(v == 8'hFF, "R10 test byte set", v, 8'hFF);
        host_write(8'h7D, 8'h00);
        host_read(8'h7D, v, om, oa);
        check(v == 8'h00, "R10 test byte cleared", v, 0);

        // R3: bus value after the address strobe fall does not retarget
        go_conv(1'b0);
        host_addr(8'h74);
        ad_in = 8'h7E;
        tick(3);
        strobe_a = 1'b0;
        tick(4);
        #1;
        check(ad_out == wv1(8'h74), "R3 address held", ad_out, wv1(8'h74));
        strobe_a = 1'b1;
        tick(4);

        // R11: same-cycle update while reading 0x65
        host_addr(8'h65);
        strobe_a = 1'b0;
        tick(4);
        upd_we = 1'b1; upd_addr = 8'h65; upd_data = 8'hC3;
        #1;
        check(ad_out == 8'hC3, "R11 same-cycle bypass", ad_out, 8'hC3);
        tick(1);
        upd_we = 1'b0;
        #1;
        check(ad_out == 8'hC3, "R11 value retained", ad_out, 8'hC3);
        upd_we = 1'b1; upd_addr = 8'h66; upd_data = 8'h18;
        #1;
        check(ad_out == 8'hC3, "R11 other address no effect", ad_out, 8'hC3);
        tick(1);
        upd_we = 1'b0;
        strobe_a = 1'b1;
        tick(4);
        #1;
        check(ad_oe == 1'b0, "R6 release after bypass read", ad_oe, 0);
        host_read(8'h66, v, om, oa);
        check(v == 8'h18, "R8 update stored", v, 8'h18);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_T * 150000);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule